// File: doc/BRIEF.md
# I2C Slave Controller With Status Codes

This block is the target side of a two-wire I2C bus. It watches already-synchronized SCL and SDA samples and finds START, repeated START and STOP conditions. It compares each address byte with a programmed address under a bit mask. It takes in written bytes and drives out read bytes. Each direction has a single-entry buffer.

After every bus event it reports a packed 8-bit state code. Control logic reads that code and acts on it. Whenever that logic has to act, the block holds the bus by pulling SCL low, and it raises a hold flag until the action arrives. The missing action can be an acknowledge decision, buffer space for a received byte, or a byte to transmit.

An automatic-acknowledge mode lets matched addresses and data bytes be accepted with no intervention, as long as the receive buffer has room. For 10-bit addressing, the first address byte is matched with the address set to `11110XX` (XX being the two top address bits) and a full mask. The bytes that follow are then handled as data.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, SDA and SCL pull-downs are released, `hold_o` is 0, `rx_valid_o` is 0 and `state_o` is 0x00.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP pulses `stop_o` for one cycle, releases SDA and SCL and returns to idle. In idle, clocked bits without a START are not acknowledged and not stored.
- R3: An address byte matches when, for every bit position i in 7..1 with `addr_mask_i[i]`=1, byte bit i equals `own_addr_i[i]`. Bit 0 of the byte is R/W (0 = master writes) and takes no part in the match. Setting `own_addr_i`=`11110XX`+x and mask 0xFF matches the first byte of a 10-bit address.
- R4: A matched address sets `state_o` to 0x71 for write or 0x73 for read, and the address byte is stored in the RX buffer. A non-matching address is not acknowledged (SDA stays released), leaves `state_o` and `rx_data_o` unchanged, and the rest of the transfer is ignored.
- R5: A START seen while the slave is not idle sets `state_o` to 0x41.
- R6: A received data byte sets `state_o` to 0xB1 and appears on `rx_data_o` with `rx_valid_o`=1. A pulse on `rx_rd_i` clears `rx_valid_o`, and `rx_data_o` keeps its value.
- R7: With `autoack_i`=1 and room in the RX buffer, matched addresses and data bytes are acknowledged (SDA low in the 9th clock) without any command.
- R8: With `autoack_i`=0, after a matched address or a data byte the slave holds SCL low with `hold_o`=1. An `ack_cmd_i` pulse then stores and acknowledges the byte. A `nack_cmd_i` pulse leaves the byte unstored, NACKs it, and ignores further bytes until START or STOP.
- R9: If the RX buffer is full when a byte is to be acknowledged, SCL is held low until `rx_rd_i` frees the buffer. The byte is then stored and acknowledged.
- R10: After a read address is acknowledged, the buffered TX byte is sent MSB first. If the TX buffer is empty, SCL is held low until `tx_wr_i`. A `tx_wr_i` pulse replaces any byte already buffered.
- R11: A sent byte that the master ACKs sets `state_o` to 0xD5, and the next byte comes from the TX buffer (with a hold if it is empty). A NACKed byte sets 0xDD, releases SDA, and nothing more is sent until START or STOP.
- R12: The SDA pull-down only starts while SCL is low, and the SCL hold only starts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| own_addr_i | input | 8 | Slave address in bits 7:1, bit 0 unused |
| addr_mask_i | input | 8 | Bits 7:1 select which address bits are compared |
| autoack_i | input | 1 | Automatic acknowledge enable |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Load `tx_data_i` into the TX buffer |
| rx_rd_i | input | 1 | Release the RX buffer |
| ack_cmd_i | input | 1 | Acknowledge the pending byte |
| nack_cmd_i | input | 1 | Refuse the pending byte |
| sda_pd_o | output | 1 | SDA pull-down enable |
| scl_pd_o | output | 1 | SCL pull-down enable (bus hold) |
| rx_data_o | output | 8 | Last stored received byte |
| rx_valid_o | output | 1 | RX buffer holds an unread byte |
| state_o | output | 8 | Status code of the last bus event |
| hold_o | output | 1 | Bus held, waiting for an action |
| stop_o | output | 1 | One-cycle pulse on STOP |

## Verification
On every cycle the assertions check three things. The SDA pull-down and the SCL hold only begin while SCL is low. A STOP leaves both lines released. The RX buffer is never written while full, and a write lands the assembled byte in it. The transmit phase also never holds the bus. Only the bench's scenarios can show the remaining behaviour: the masked and 10-bit address decisions, the status-code sequence across repeated START, receive and transmit, and the three kinds of bus hold with the actions that end them. The bench drives a bus master that honours clock stretching and reacts to the hold flag.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AWAIT, PH_ACK, PH_RX,
    PH_TX, PH_TACK, PH_TNEXT, PH_TWAIT, PH_IGN
  } phase_t;

  localparam logic [CODE_W-1:0] ST_RESET  = 8'h00;
  localparam logic [CODE_W-1:0] ST_RSTART = 8'h41;
  localparam logic [CODE_W-1:0] ST_ADR_WR = 8'h71;
  localparam logic [CODE_W-1:0] ST_ADR_RD = 8'h73;
  localparam logic [CODE_W-1:0] ST_RX_BYT = 8'hB1;
  localparam logic [CODE_W-1:0] ST_TX_ACK = 8'hD5;
  localparam logic [CODE_W-1:0] ST_TX_NAK = 8'hDD;

  // address compare: bit 0 (direction) never takes part
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx_b,
                                    input logic [BYTE_W-1:0] own,
                                    input logic [BYTE_W-1:0] msk);
    logic [BYTE_W-1:0] diff;
    diff = (rx_b ^ own) & msk;
    diff[0] = 1'b0;
    return (diff == '0);
  endfunction
endpackage

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] addr_mask,
  output logic              hit,
  output logic              is_read
);
  assign hit     = addr_hit(rx_byte, own_addr, addr_mask);
  assign is_read = rx_byte[0];
endmodule

// File: rtl/i2cs_byte_buf.sv
module i2cs_byte_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (push) begin
      full <= 1'b1;
      data <= push_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] own_addr_i,
  input  logic [BYTE_W-1:0] addr_mask_i,
  input  logic              autoack_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic              ack_cmd_i,
  input  logic              nack_cmd_i,
  output logic              sda_pd_o,
  output logic              scl_pd_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [CODE_W-1:0] state_o,
  output logic              hold_o,
  output logic              stop_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic hit, is_read;
  logic rx_full, tx_full;
  logic [BYTE_W-1:0] rx_dat, tx_dat;

  phase_t            phase;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              sda_pd, hold, rw_q, ack_armed, stop_q;
  logic              rx_push, tx_pop;
  logic [CODE_W-1:0] state_q;

  i2cs_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_addr_match u_match (
    .rx_byte(shreg), .own_addr(own_addr_i), .addr_mask(addr_mask_i),
    .hit(hit), .is_read(is_read)
  );

  i2cs_byte_buf #(.W(BYTE_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(shreg),
    .pop(rx_rd_i), .full(rx_full), .data(rx_dat)
  );

  i2cs_byte_buf #(.W(BYTE_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .push(tx_wr_i), .push_data(tx_data_i),
    .pop(tx_pop), .full(tx_full), .data(tx_dat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sda_pd    <= 1'b0;
      hold      <= 1'b0;
      rw_q      <= 1'b0;
      ack_armed <= 1'b0;
      stop_q    <= 1'b0;
      rx_push   <= 1'b0;
      tx_pop    <= 1'b0;
      state_q   <= ST_RESET;
    end else begin
      rx_push <= 1'b0;
      tx_pop  <= 1'b0;
      stop_q  <= 1'b0;
      if (stop_evt) begin
        phase     <= PH_IDLE;
        hold      <= 1'b0;
        sda_pd    <= 1'b0;
        ack_armed <= 1'b0;
        stop_q    <= 1'b1;
      end else if (start_evt) begin
        if (phase != PH_IDLE) state_q <= ST_RSTART;
        phase     <= PH_ADDR;
        bitcnt    <= '0;
        hold      <= 1'b0;
        sda_pd    <= 1'b0;
        ack_armed <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR, PH_RX: begin
            if (scl_rise && bitcnt != LAST_BIT) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (phase == PH_ADDR && !hit) begin
                phase <= PH_IGN;
              end else begin
                if (phase == PH_ADDR) begin
                  rw_q    <= is_read;
                  state_q <= is_read ? ST_ADR_RD : ST_ADR_WR;
                end else begin
                  state_q <= ST_RX_BYT;
                end
                if (autoack_i && !rx_full) begin
                  rx_push <= 1'b1;
                  sda_pd  <= 1'b1;
                  phase   <= PH_ACK;
                end else begin
                  hold  <= 1'b1;
                  phase <= PH_AWAIT;
                end
              end
            end
          end
          PH_AWAIT: begin
            if (nack_cmd_i) begin
              hold      <= 1'b0;
              ack_armed <= 1'b0;
              phase     <= PH_IGN;
            end else if ((autoack_i || ack_armed || ack_cmd_i) && !rx_full) begin
              rx_push   <= 1'b1;
              sda_pd    <= 1'b1;
              hold      <= 1'b0;
              ack_armed <= 1'b0;
              phase     <= PH_ACK;
            end else if (ack_cmd_i) begin
              ack_armed <= 1'b1;
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              sda_pd <= 1'b0;
              if (!rw_q) begin
                phase <= PH_RX;
              end else if (tx_full) begin
                shreg  <= tx_dat;
                sda_pd <= ~tx_dat[BYTE_W-1];
                tx_pop <= 1'b1;
                phase  <= PH_TX;
              end else begin
                hold  <= 1'b1;
                phase <= PH_TWAIT;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt != '0) begin
              if (bitcnt == LAST_BIT) begin
                sda_pd <= 1'b0;
                phase  <= PH_TACK;
              end else begin
                sda_pd <= ~shreg[BYTE_W-2];
                shreg  <= shreg << 1;
              end
            end
          end
          PH_TACK: begin
            if (scl_rise) begin
              if (!sda_i) begin
                state_q <= ST_TX_ACK;
                phase   <= PH_TNEXT;
              end else begin
                state_q <= ST_TX_NAK;
                phase   <= PH_IGN;
              end
            end
          end
          PH_TNEXT: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (tx_full) begin
                shreg  <= tx_dat;
                sda_pd <= ~tx_dat[BYTE_W-1];
                tx_pop <= 1'b1;
                phase  <= PH_TX;
              end else begin
                hold  <= 1'b1;
                phase <= PH_TWAIT;
              end
            end
          end
          PH_TWAIT: begin
            if (tx_full) begin
              shreg  <= tx_dat;
              sda_pd <= ~tx_dat[BYTE_W-1];
              tx_pop <= 1'b1;
              hold   <= 1'b0;
              bitcnt <= '0;
              phase  <= PH_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o   = sda_pd;
  assign scl_pd_o   = hold;
  assign hold_o     = hold;
  assign stop_o     = stop_q;
  assign state_o    = state_q;
  assign rx_data_o  = rx_dat;
  assign rx_valid_o = rx_full;

  // R12
  sda_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd) |-> !$past(scl_i));

  // R12
  scl_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !$past(scl_i));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!scl_pd_o && !sda_pd_o));

  // R9
  rx_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R6
  rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (rx_full && rx_dat == $past(shreg)));

  // R10
  tx_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TX) |-> !hold);
endmodule

// File: tb/test_i2cs_slave.sv
module test_i2cs_slave;
  localparam int Q = 4;
  localparam int NV = 9;
  // {own, mask, byte, expected ack, expected state}
  localparam logic [39:0] VEC [NV] = '{
    {8'h84, 8'hFE, 8'h84, 8'h01, 8'h71},
    {8'h84, 8'hFE, 8'h85, 8'h01, 8'h73},
    {8'h84, 8'hFE, 8'h86, 8'h00, 8'h73},
    {8'h84, 8'hF8, 8'h86, 8'h01, 8'h71},
    {8'h84, 8'hF8, 8'h8E, 8'h00, 8'h71},
    {8'hF6, 8'hFF, 8'hF6, 8'h01, 8'h71},
    {8'hF6, 8'hFF, 8'hF2, 8'h00, 8'h71},
    {8'hF6, 8'hFF, 8'hF7, 8'h01, 8'h73},
    {8'h84, 8'h00, 8'h10, 8'h01, 8'h71}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic [7:0] own_addr, addr_mask, tx_data;
  logic autoack, tx_wr, ack_cmd, nack_cmd, auto_drain, man_rd;
  logic sda_pd, scl_pd, rx_valid, hold, stop_p;
  logic [7:0] rx_data, state;
  logic scl_line, sda_line, rx_rd;

  assign scl_line = scl_m & ~scl_pd;
  assign sda_line = sda_m & ~sda_pd;
  assign rx_rd    = auto_drain ? rx_valid : man_rd;

  i2cs_slave i_i2cs_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr_i(own_addr), .addr_mask_i(addr_mask), .autoack_i(autoack),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd),
    .ack_cmd_i(ack_cmd), .nack_cmd_i(nack_cmd),
    .sda_pd_o(sda_pd), .scl_pd_o(scl_pd), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .state_o(state), .hold_o(hold), .stop_o(stop_p)
  );

  int n_tests = 0, n_fail = 0, stop_cnt = 0, r12_viol = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (rst_n && stop_p) stop_cnt++;
  end

  initial begin
    logic p_sda, p_scl;
    p_sda = 1'b0; p_scl = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (rst_n && sda_pd && !p_sda && scl_line && p_scl) r12_viol++;
      p_sda = sda_pd; p_scl = scl_line;
    end
  end

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl(); hw(1); while (!scl_line) hw(1); endtask
  task automatic m_start(); sda_m = 1; scl_m = 1; hw(Q); sda_m = 0; hw(Q); scl_m = 0; hw(Q); endtask
  task automatic m_rstart(); sda_m = 1; hw(Q); scl_m = 1; wait_scl(); hw(Q); sda_m = 0; hw(Q); scl_m = 0; hw(Q); endtask
  task automatic m_stop(); sda_m = 0; hw(Q); scl_m = 1; wait_scl(); hw(Q); sda_m = 1; hw(Q); endtask
  task automatic m_wbit(input logic b); sda_m = b; hw(Q); scl_m = 1; wait_scl(); hw(Q); scl_m = 0; hw(Q); endtask
  task automatic m_rbit(output logic b); sda_m = 1; hw(Q); scl_m = 1; wait_scl(); hw(Q); b = sda_line; scl_m = 0; hw(Q); endtask
  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = ~b;
  endtask
  task automatic m_rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
    m_wbit(~ack);
  endtask
  task automatic pulse_tx(input logic [7:0] d); tx_data = d; tx_wr = 1; hw(1); tx_wr = 0; endtask
  task automatic pulse_ack(); ack_cmd = 1; hw(1); ack_cmd = 0; endtask
  task automatic pulse_nack(); nack_cmd = 1; hw(1); nack_cmd = 0; endtask
  task automatic pulse_rd(); man_rd = 1; hw(1); man_rd = 0; endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d, last_rx;
    int sc;
    rst_n = 0; scl_m = 1; sda_m = 1; own_addr = 8'h84; addr_mask = 8'hFE;
    autoack = 1; tx_data = 0; tx_wr = 0; ack_cmd = 0; nack_cmd = 0;
    auto_drain = 1; man_rd = 0;
    hw(5); rst_n = 1; hw(2);

    // R1 reset state
    chk("R1 sda_pd", sda_pd, 0);
    chk("R1 scl_pd", scl_pd, 0);
    chk("R1 hold", hold, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 state", state, 8'h00);

    // vector table: R3 R4 R7 address decisions with autoack
    last_rx = 8'h00;
    for (int v = 0; v < NV; v++) begin
      own_addr = VEC[v][39:32]; addr_mask = VEC[v][31:24];
      pulse_tx(8'hFF);
      m_start();
      m_wbyte(VEC[v][23:16], ack);
      m_stop();
      chk($sformatf("R3 vec%0d ack", v), ack, VEC[v][8]);
      chk($sformatf("R4 vec%0d state", v), state, VEC[v][7:0]);
      if (VEC[v][8]) last_rx = VEC[v][23:16];
      chk($sformatf("R4 vec%0d rx_data", v), rx_data, last_rx);
    end

    // R6 R7 write with data, R2 stop handling
    own_addr = 8'h84; addr_mask = 8'hFE;
    m_start();
    m_wbyte(8'h84, ack);
    m_wbyte(8'h5A, ack);
    chk("R7 data autoack", ack, 1);
    chk("R6 state B1", state, 8'hB1);
    chk("R6 rx_data", rx_data, 8'h5A);
    sc = stop_cnt;
    m_stop();
    chk("R2 stop pulse", stop_cnt, sc + 1);
    chk("R2 lines released", {sda_pd, scl_pd}, 2'b00);
    scl_m = 0; hw(Q);
    m_wbyte(8'h84, ack);
    chk("R2 idle ignores bits", ack, 0);
    chk("R2 idle no store", rx_data, 8'h5A);
    m_stop();

    // R8 software acknowledge
    autoack = 0;
    m_start();
    fork
      m_wbyte(8'h84, ack);
      begin
        wait (hold === 1'b1); hw(1);
        chk("R8 addr hold state", state, 8'h71);
        chk("R8 scl held", scl_pd, 1);
        hw(20);
        chk("R8 still held", {hold, sda_pd}, 2'b10);
        pulse_ack();
      end
    join
    chk("R8 addr acked by cmd", ack, 1);
    fork
      m_wbyte(8'h3C, ack);
      begin
        wait (hold === 1'b1); hw(1);
        chk("R8 data hold state", state, 8'hB1);
        pulse_ack();
      end
    join
    chk("R8 data acked", ack, 1);
    chk("R8 data stored", rx_data, 8'h3C);
    fork
      m_wbyte(8'h99, ack);
      begin wait (hold === 1'b1); hw(1); pulse_nack(); end
    join
    chk("R8 nack on bus", ack, 0);
    chk("R8 nack not stored", rx_data, 8'h3C);
    m_wbyte(8'h11, ack);
    chk("R8 ignored after nack", {ack, hold}, 2'b00);
    m_stop();

    // R9 buffer full hold, R6 read clears valid
    autoack = 1; auto_drain = 0;
    m_start();
    m_wbyte(8'h84, ack);
    chk("R6 rx_valid set", rx_valid, 1);
    fork
      m_wbyte(8'h77, ack);
      begin
        wait (hold === 1'b1); hw(1);
        chk("R9 hold state", state, 8'hB1);
        chk("R9 old byte kept", rx_data, 8'h84);
        hw(30);
        chk("R9 held while full", {hold, scl_line}, 2'b10);
        pulse_rd();
      end
    join
    chk("R9 acked after read", ack, 1);
    chk("R9 new byte stored", rx_data, 8'h77);
    pulse_rd(); hw(1);
    chk("R6 rd clears valid", rx_valid, 0);
    chk("R6 data kept after rd", rx_data, 8'h77);
    m_stop();
    auto_drain = 1;

    // R5 repeated start, R10 R11 transmit
    m_start();
    m_wbyte(8'h84, ack);
    m_wbyte(8'h21, ack);
    m_rstart();
    chk("R5 repeated start", state, 8'h41);
    pulse_tx(8'h11);
    pulse_tx(8'hA5);
    m_wbyte(8'h85, ack);
    chk("R4 read addr state", state, 8'h73);
    m_rbyte(d, 1'b1);
    chk("R10 tx byte overwrite", d, 8'hA5);
    chk("R11 state D5", state, 8'hD5);
    hw(2);
    chk("R10 hold tx empty", {hold, scl_pd}, 2'b11);
    pulse_tx(8'h3C);
    m_rbyte(d, 1'b0);
    chk("R10 second byte", d, 8'h3C);
    chk("R11 state DD", state, 8'hDD);
    chk("R11 released after nack", {hold, sda_pd}, 2'b00);
    m_stop();

    chk("R12 sda only starts low", r12_viol, 0);
    finish_run();
  end
endmodule